// File: doc/BRIEF.md
# SPI Controller with Mode-Fault Detection

This block is a byte-wide SPI peripheral that acts as either the clock-driving master or a clock-following slave. It sits behind a small register bus: one control register, one status register and one data register. The block uses SPI mode 0 only: SCK idles low, data is sampled on the rising edge and changes on the falling edge. There is a single shift register and no transmit holding stage. A write to the data register goes straight into the shifter. A read of the data register returns a separate one-byte receive buffer, which is refreshed only when a whole byte has arrived.

The slave-select pin is watched in both roles. A master that sees slave-select pulled low by another device switches itself off. A slave that sees slave-select rise part-way through a byte throws that byte away and waits for the next selection. One interrupt output is driven from the flags. When the transmit-empty interrupt is enabled, it replaces the transfer-complete interrupt.

The bus is a plain register interface with no back-pressure. A read or write completes in the cycle it is presented. Read data is combinational while `bus_rd` is high. The side effects of a read take place at the following clock edge.

Top module: `spi_mf_core`

## Requirements
- R1: After reset, status (address 1) reads 0x02, control (address 0) reads 0x00, and `irq` and `sck_o` are low.
- R2: A data-register (address 2) write is accepted only while the block is enabled (control bit 0) and transmit-empty is set. An accepted write loads the shift register directly. Any other data write is ignored and starts no transfer.
- R3: A data-register read returns the receive buffer. During a transfer it still returns the byte from the previous completed transfer.
- R4: In master mode (control bit 1 = 1), `sck_o` idles low and gives 8 pulses per byte. Each SCK half-period lasts (div+1) clock cycles, where div is control bits 4:2. MOSI changes on falling edges and MISO is sampled on rising edges.
- R5: Status bit 3 selects the bit order: 0 (the reset value) sends and receives MSB first, 1 sends and receives LSB first.
- R6: Transfer-complete (status bit 0) is set when the eighth bit has been shifted, at the moment the received byte enters the receive buffer. A data access clears it only after a status read has seen it set.
- R7: Transmit-empty (status bit 1) clears when a byte is loaded and sets again when that byte completes or is aborted.
- R8: A mode fault in master mode occurs when the enabled master sees `ss_n_i` low. It sets the fault flag (status bit 2), clears the enable bit and aborts the transfer.
- R9: A mode fault in slave mode occurs when `ss_n_i` rises in the middle of a byte. It sets the fault flag, discards the partial byte (no completion, receive buffer unchanged), and the next selected byte is received normally.
- R10: Reading the status register clears the fault flag.
- R11: `irq` is high while the fault flag and the fault interrupt enable (status bit 5) are both set.
- R12: With the transmit-empty interrupt enable (status bit 4) at 0, transfer-complete drives `irq` when control bit 5 is set. With it at 1, `irq` instead follows a pending bit that a rising transmit-empty sets and a status read clears, and transfer-complete raises no interrupt.
- R13: In slave mode (control bit 1 = 0), SCK, MOSI and slave-select pass through a two-stage synchronizer. The slave shifts only while selected, and SCK activity while `ss_n_i` is high leaves the shifter and flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when `bus_rd` is low |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out, low when not selected |
| ss_n_i | input | 1 | Active-low slave-select pin |

## Verification
The assertions assume the following about the inputs:
- Each slave-side SCK half-period lasts several system clocks, longer than the synchronizer delay plus edge detection.
- `ss_n_i` and `mosi_i` change only while SCK is low.
- `bus_rd` and `bus_wr` are never raised together.

The bench respects these limits. Its model of a remote master holds every SCK level and every select setup for eight clock cycles. Its model of a remote slave changes MISO only on falling SCK edges, and it issues one bus operation at a time.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_DATA = 2'd2;

  // control register bit positions (divider field and done-enable follow)
  localparam int C_EN     = 0;
  localparam int C_MST    = 1;
  localparam int C_DIV_LO = 2;

  // status register bit positions
  localparam int S_DONE   = 0;
  localparam int S_TXE    = 1;
  localparam int S_FLT    = 2;
  localparam int S_LSB    = 3;
  localparam int S_TXE_IE = 4;
  localparam int S_FLT_IE = 5;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              sample,
  input  logic              sample_bit,
  input  logic              shift,
  input  logic              lsb_first,
  output logic              out_bit,
  output logic [DATA_W-1:0] shifted
);
  logic [DATA_W-1:0] sr_q;
  logic              cap_q;

  // captured bit enters at the end opposite to the one leaving
  assign shifted = lsb_first ? {cap_q, sr_q[DATA_W-1:1]}
                             : {sr_q[DATA_W-2:0], cap_q};
  assign out_bit = lsb_first ? sr_q[0] : sr_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cap_q <= 1'b0;
    end else begin
      if (sample) cap_q <= sample_bit;
      if (load)       sr_q <= load_val;
      else if (shift) sr_q <= shifted;
    end
  end

  // R2: a load never collides with a shift of a byte in flight
  p_no_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift);
endmodule

// File: rtl/spi_mf_master_seq.sv
module spi_mf_master_seq #(
  parameter int DATA_W = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             busy,
  output logic             sample_p,
  output logic             shift_p,
  output logic             byte_end
);
  localparam int HALVES = 2 * DATA_W;
  localparam int HC_W = $clog2(HALVES);
  localparam logic [HC_W-1:0] LAST_HALF = HC_W'(HALVES - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [HC_W-1:0]  half_q;
  logic             tick;

  assign tick     = busy && !abort && !start && (cnt_q == div);
  assign sample_p = tick && !sck;
  assign shift_p  = tick && sck;
  assign byte_end = shift_p && (half_q == LAST_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      sck    <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt_q  <= '0;
        sck    <= ~sck;
        half_q <= half_q + 1'b1;
        if (half_q == LAST_HALF) busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the clock rests low whenever no byte is in flight
  p_sck_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R4: the final edge of a byte is a falling one that ends the sequence
  p_last_edge_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (!sck && !busy));
endmodule

// File: rtl/spi_mf_slave_seq.sv
module spi_mf_slave_seq #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sck_s,
  input  logic ss_s,
  output logic sample_p,
  output logic shift_p,
  output logic byte_end,
  output logic in_byte,
  output logic fault_p
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  logic            sck_d_q;
  logic            ss_d_q;
  logic            half_q;
  logic [BC_W-1:0] bcnt_q;
  logic            sel;

  assign sel      = enable && !ss_s;
  assign sample_p = sel && sck_s && !sck_d_q;
  assign shift_p  = sel && !sck_s && sck_d_q && half_q;
  assign byte_end = shift_p && (bcnt_q == LAST_BIT);
  assign in_byte  = half_q || (bcnt_q != '0);
  assign fault_p  = enable && ss_s && !ss_d_q && in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      ss_d_q  <= 1'b1;
      half_q  <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      sck_d_q <= sck_s;
      ss_d_q  <= ss_s;
      if (!sel) begin
        half_q <= 1'b0;
        bcnt_q <= '0;
      end else begin
        if (sample_p) half_q <= 1'b1;
        if (shift_p) begin
          half_q <= 1'b0;
          bcnt_q <= (bcnt_q == LAST_BIT) ? '0 : bcnt_q + 1'b1;
        end
      end
    end
  end

  // R9: deselection mid-byte leaves no partial count behind
  p_deselect_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_p |=> (bcnt_q == '0 && !half_q));
  // R13: no edge is acted on while the select line is high
  p_quiet_unselected_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ss_d_q && ss_s |-> (bcnt_q == '0 && !half_q));
endmodule

// File: rtl/spi_mf_core.sv
module spi_mf_core import spi_mf_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq,
  output logic                  sck_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  input  logic                  sck_i,
  input  logic                  mosi_i,
  output logic                  miso_o,
  input  logic                  ss_n_i
);
  localparam int C_DONE_IE = C_DIV_LO + DIV_W;
  localparam int PIN_N = 3;

  // register state
  logic              en_q, mst_q, done_ie_q;
  logic [DIV_W-1:0]  div_q;
  logic              done_q, txe_q, flt_q, lsb_q, txe_ie_q, flt_ie_q;
  logic              armed_q, pend_q;
  logic [DATA_W-1:0] rx_q;

  // synchronized pins
  logic ss_s, sck_s, mosi_s;

  spi_mf_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_i, sck_i, mosi_i}),
    .q({ss_s, sck_s, mosi_s})
  );

  // bus decode
  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign rd_data = bus_rd && (bus_addr == A_DATA);

  logic master_mode, slave_mode;
  assign master_mode = en_q && mst_q;
  assign slave_mode  = en_q && !mst_q;

  // sequencers
  logic m_sck, m_busy, m_sample, m_shift, m_end, m_abort, m_fault;
  logic s_sample, s_shift, s_end, s_in_byte, s_fault;
  logic load;

  assign m_fault = master_mode && !ss_s;
  assign m_abort = m_fault || !master_mode;
  assign load    = wr_data && en_q && txe_q && !(slave_mode && s_in_byte);

  spi_mf_master_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mseq (
    .clk(clk), .rst_n(rst_n),
    .start(load && master_mode), .abort(m_abort), .div(div_q),
    .sck(m_sck), .busy(m_busy),
    .sample_p(m_sample), .shift_p(m_shift), .byte_end(m_end)
  );

  spi_mf_slave_seq #(.DATA_W(DATA_W)) u_sseq (
    .clk(clk), .rst_n(rst_n),
    .enable(slave_mode), .sck_s(sck_s), .ss_s(ss_s),
    .sample_p(s_sample), .shift_p(s_shift), .byte_end(s_end),
    .in_byte(s_in_byte), .fault_p(s_fault)
  );

  // shared shift register
  logic              out_bit;
  logic [DATA_W-1:0] shifted;
  logic              byte_end;
  assign byte_end = m_end || s_end;

  spi_mf_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(bus_wdata),
    .sample(m_sample || s_sample),
    .sample_bit(mst_q ? miso_i : mosi_s),
    .shift(m_shift || s_shift),
    .lsb_first(lsb_q),
    .out_bit(out_bit), .shifted(shifted)
  );

  // flags and configuration
  logic txe_set;
  assign txe_set = byte_end || m_fault || s_fault || (m_busy && !master_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;  mst_q <= 1'b0;  div_q <= '0;  done_ie_q <= 1'b0;
      done_q <= 1'b0; txe_q <= 1'b1; flt_q <= 1'b0;
      lsb_q <= 1'b0; txe_ie_q <= 1'b0; flt_ie_q <= 1'b0;
      armed_q <= 1'b0; pend_q <= 1'b0;
      rx_q <= '0;
    end else begin
      if (m_fault)      en_q <= 1'b0;
      else if (wr_ctrl) en_q <= bus_wdata[C_EN];
      if (wr_ctrl) begin
        mst_q     <= bus_wdata[C_MST];
        div_q     <= bus_wdata[C_DIV_LO +: DIV_W];
        done_ie_q <= bus_wdata[C_DONE_IE];
      end
      if (wr_stat) begin
        lsb_q    <= bus_wdata[S_LSB];
        txe_ie_q <= bus_wdata[S_TXE_IE];
        flt_ie_q <= bus_wdata[S_FLT_IE];
      end

      if (txe_set)   txe_q <= 1'b1;
      else if (load) txe_q <= 1'b0;

      if (txe_set && !txe_q) pend_q <= 1'b1;
      else if (rd_stat)      pend_q <= 1'b0;

      if (byte_end) rx_q <= shifted;

      if (byte_end)                              done_q <= 1'b1;
      else if (armed_q && (rd_data || wr_data))  done_q <= 1'b0;

      if (rd_stat && done_q)         armed_q <= 1'b1;
      else if (rd_data || wr_data)   armed_q <= 1'b0;

      if (m_fault || s_fault) flt_q <= 1'b1;
      else if (rd_stat)       flt_q <= 1'b0;
    end
  end

  // interrupt steering
  assign irq = (flt_q && flt_ie_q) || (txe_ie_q ? pend_q : (done_q && done_ie_q));

  // pins
  assign sck_o  = m_sck;
  assign mosi_o = master_mode && out_bit;
  assign miso_o = slave_mode && !ss_s && out_bit;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL: begin
          bus_rdata[C_EN]               = en_q;
          bus_rdata[C_MST]              = mst_q;
          bus_rdata[C_DIV_LO +: DIV_W]  = div_q;
          bus_rdata[C_DONE_IE]          = done_ie_q;
        end
        A_STAT: begin
          bus_rdata[S_DONE]   = done_q;
          bus_rdata[S_TXE]    = txe_q;
          bus_rdata[S_FLT]    = flt_q;
          bus_rdata[S_LSB]    = lsb_q;
          bus_rdata[S_TXE_IE] = txe_ie_q;
          bus_rdata[S_FLT_IE] = flt_ie_q;
        end
        A_DATA:  bus_rdata = rx_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R3: the receive buffer moves only at the end of a byte
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_end |=> $stable(rx_q));
  // R7: transmit-empty only drops after an accepted load
  p_txe_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txe_q) |-> $past(load));
  // R8: select low on an enabled master flags a fault and switches it off
  p_master_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mst_q && !ss_s) |=> (flt_q && !en_q));
  // R9: an aborted slave byte never completes
  p_slave_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_fault |-> !byte_end);
  // R10: a status read with no new fault leaves the flag clear
  p_fault_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !m_fault && !s_fault) |=> !flt_q);
  // R12: with the empty interrupt selected, completion alone raises nothing
  p_tc_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_ie_q && !pend_q && !(flt_q && flt_ie_q)) |-> !irq);
endmodule

// File: tb/tb_spi_mf_core.sv
module tb_spi_mf_core;
  localparam int HALF = 10;          // 20 time units per cycle, 50 MHz
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, sck_o, mosi_o, miso_o;
  logic miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] prev_rx = 8'h00;

  always #HALF clk = ~clk;

  spi_mf_core dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  function automatic logic [7:0] exp_stat(input bit done, input bit txe, input bit flt,
                                          input bit lsb, input bit tie, input bit fie);
    return {2'b00, fie, tie, lsb, flt, txe, done};
  endfunction

  function automatic int bit_pos(input bit lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int k = 0; k < 300; k++) begin
      bus_read(A_STAT, s);
      if (s[0]) begin ok = 1'b1; break; end
    end
  endtask

  // bench acts as remote slave while the design is master
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sl, input int div,
                             input bit lsb);
    logic [7:0] mo, rx; time tr, tf; bit ok;
    mo = '0; tr = 0; tf = 0;
    miso_i = sl[bit_pos(lsb, 0)];
    bus_write(A_DATA, tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o); #1; tr = $time; mo[bit_pos(lsb, i)] = mosi_o;
      @(negedge sck_o); tf = $time;
      if (i < 7) miso_i = sl[bit_pos(lsb, i + 1)];
    end
    chk("R4 half-period cycles", int'((tf - tr + 1) / (2 * HALF)), div + 1);
    chk("R5 MOSI bit order", mo, tx);
    wait_done(ok);
    chk("R6 done after master byte", ok, 1);
    bus_read(A_DATA, rx);
    chk("R5 received byte order", rx, sl);
    prev_rx = rx;
    #1 chk("R4 sck idle after byte", sck_o, 0);
  endtask

  // bench acts as remote master while the design is slave
  task automatic remote_bits(input logic [7:0] mo, input bit lsb, input int nbits,
                             output logic [7:0] mi);
    mi = '0;
    ss_n_i = 1'b0; repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = mo[bit_pos(lsb, i)];
      repeat (8) @(negedge clk);
      sck_i = 1'b1; mi[bit_pos(lsb, i)] = miso_o;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] mo, input bit lsb);
    logic [7:0] mi, rx; bit ok;
    bus_write(A_DATA, tx);
    remote_bits(mo, lsb, 8, mi);
    chk("R13 slave MISO byte", mi, tx);
    wait_done(ok);
    chk("R6 done after slave byte", ok, 1);
    bus_read(A_DATA, rx);
    chk("R13 slave received byte", rx, mo);
    prev_rx = rx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r, mi;
    int div; bit lsb, ok;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(A_STAT, r); chk("R1 status reset", r, 8'h02);
    bus_read(A_CTRL, r); chk("R1 control reset", r, 8'h00);
    chk("R1 irq reset", irq, 0);
    chk("R1 sck reset", sck_o, 0);

    // R2 data write while disabled is ignored
    bus_write(A_DATA, 8'h81);
    repeat (20) @(negedge clk);
    chk("R2 disabled write no sck", sck_o, 0);
    bus_read(A_STAT, r); chk("R2 disabled write keeps txe", r, exp_stat(0, 1, 0, 0, 0, 0));

    // random master transfers, R4 R5 R6
    for (int n = 0; n < 10; n++) begin
      div = $urandom_range(0, 7);
      lsb = 1'($urandom_range(0, 1));
      bus_write(A_CTRL, 8'h03 | 8'(div << 2));
      bus_write(A_STAT, {4'b0, lsb, 3'b0});
      master_xfer(8'($urandom), 8'($urandom), div, lsb);
    end

    // R2 R3 R7 mid-transfer behaviour
    bus_write(A_CTRL, 8'h1F);
    bus_write(A_STAT, 8'h00);
    miso_i = 1'b1;
    bus_write(A_DATA, 8'h3C);
    bus_read(A_STAT, r); chk("R7 txe low while busy", r, exp_stat(0, 0, 0, 0, 0, 0));
    bus_read(A_DATA, r); chk("R3 data read mid-transfer", r, prev_rx);
    bus_write(A_DATA, 8'h99);
    wait_done(ok); chk("R6 done after long byte", ok, 1);
    bus_read(A_DATA, r); chk("R6 rx of long byte", r, 8'hFF);
    prev_rx = r;
    bus_read(A_STAT, r); chk("R7 txe back and done cleared", r, exp_stat(0, 1, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk("R2 busy write started nothing", sck_o, 0);

    // R6 data access alone does not clear done
    bus_write(A_CTRL, 8'h03);
    miso_i = 1'b0;
    bus_write(A_DATA, 8'h55);
    repeat (40) @(negedge clk);
    bus_read(A_DATA, r); chk("R6 rx updated", r, 8'h00);
    bus_read(A_STAT, r); chk("R6 done kept without status read", r, exp_stat(1, 1, 0, 0, 0, 0));
    bus_read(A_DATA, r);
    bus_read(A_STAT, r); chk("R6 done cleared by sequence", r, exp_stat(0, 1, 0, 0, 0, 0));
    prev_rx = 8'h00;

    // R12 interrupt steering
    bus_write(A_CTRL, 8'h23);
    bus_write(A_DATA, 8'hC3);
    repeat (40) @(negedge clk);
    chk("R12 done interrupt", irq, 1);
    bus_write(A_STAT, 8'h10);
    chk("R12 pending empty interrupt", irq, 1);
    bus_read(A_STAT, r);
    chk("R12 done masked by empty enable", irq, 0);
    bus_write(A_DATA, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R12 empty rising raises irq", irq, 1);
    bus_read(A_STAT, r);
    chk("R12 status read clears pending", irq, 0);
    bus_write(A_STAT, 8'h00);
    chk("R12 done interrupt restored", irq, 1);
    bus_read(A_STAT, r);
    bus_read(A_DATA, r); prev_rx = r;
    chk("R12 irq gone after clear", irq, 0);

    // R8 R10 R11 master mode fault
    bus_write(A_CTRL, 8'h03);
    bus_write(A_STAT, 8'h20);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 fault interrupt", irq, 1);
    bus_read(A_CTRL, r); chk("R8 enable cleared", r, 8'h02);
    ss_n_i = 1'b1;
    bus_read(A_STAT, r); chk("R8 fault flag set", r, exp_stat(0, 1, 1, 0, 0, 1));
    bus_read(A_STAT, r); chk("R10 fault cleared by read", r, exp_stat(0, 1, 0, 0, 0, 1));
    chk("R11 irq drops with flag", irq, 0);
    repeat (6) @(negedge clk);

    // random slave transfers, R13 R5
    bus_write(A_CTRL, 8'h01);
    for (int n = 0; n < 6; n++) begin
      lsb = 1'($urandom_range(0, 1));
      bus_write(A_STAT, {4'b0, lsb, 3'b0});
      slave_xfer(8'($urandom), 8'($urandom), lsb);
    end

    // R9 slave mode fault
    bus_write(A_STAT, 8'h00);
    bus_write(A_DATA, 8'hE7);
    remote_bits(8'h5A, 1'b0, 3, mi);
    bus_read(A_STAT, r); chk("R9 slave fault flag", r, exp_stat(0, 1, 1, 0, 0, 0));
    bus_read(A_DATA, r); chk("R9 rx unchanged", r, prev_rx);
    slave_xfer(8'h6B, 8'hB4, 1'b0);

    // R13 activity while deselected is ignored
    bus_write(A_DATA, 8'hA5);
    for (int i = 0; i < 8; i++) begin
      mosi_i = 1'(i); repeat (8) @(negedge clk);
      sck_i = 1'b1; repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    bus_read(A_STAT, r); chk("R13 deselected no flags", r, exp_stat(0, 0, 0, 0, 0, 0));
    remote_bits(8'h1E, 1'b0, 8, mi);
    chk("R13 shifter untouched while deselected", mi, 8'hA5);
    wait_done(ok);
    bus_read(A_DATA, r); chk("R13 byte after idle clocks", r, 8'h1E);

    summary();
    $finish;
  end
endmodule